// File: doc/BRIEF.md
# Duty-Cycled Receiver Wake Sequencer

The sequencer runs a group of receiver modules through a repeating low-power poll. Each poll has four timed phases: a sleep gap, a host wake-up window, a settle time for the RF front end, and a listen window. Each phase is counted in ticks of an external prescaled timebase. During the wake-up window the block pulls down a shared, pulled-up handshake line. The host answers by pulling the same line low itself. If the host still holds the line when the listen window closes, the receiver stays powered until the host lets go.

The handshake line is open-drain. It appears as a drive-enable output and a sampled input. The sampled input is assumed to be already synchronised to `clk_i`. Phase lengths and the per-module enable mask come from register inputs. With duty cycling off, the enabled modules are simply held powered. A sleep input overrides every other setting.

Top module: `rxw_wake_seq`

## Requirements
- R1: After `rst_ni` is released, the block is idle. With duty cycling on, `mod_pwr_o`, `line_drive_o` and `data_en_o` are all low.
- R2: With `duty_en_i` low and `sleep_i` low, `mod_pwr_o` equals `pwr_mask_i`, `data_en_o` is high and `line_drive_o` is low. Turning duty cycling on returns the block to idle with all outputs low.
- R3: `sleep_i` high forces all three outputs low in any mode or phase and returns the sequencer to idle. This holds even when a phase would end on the same edge.
- R4: The sequence leaves idle only when `cs_i` and `line_i` are both high. It then starts the off phase on the next clock edge.
- R5: The phases run in the order off, wake, settle, listen. A phase loaded with value V ends on the (V+1)-th tick after the edge that loaded it, so zero ends on the next tick. A tick on the loading edge is not counted. The off, settle and listen values are 16 bits wide and the wake value is 8 bits wide.
- R6: `line_drive_o` is high exactly while the wake phase runs.
- R7: In duty mode, bit i of `mod_pwr_o` is high only when bit i of `pwr_mask_i` is set and the phase is settle, listen or hold. Masked-off modules never power up.
- R8: In duty mode, `data_en_o` is high only in the listen and hold phases.
- R9: If `line_i` is high on the tick that ends the listen phase, the modules power down and the off phase restarts at once.
- R10: If `line_i` is low on that tick, the block holds the modules powered and data enabled for as long as `line_i` stays low. The edge after `line_i` returns high starts a new off phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Single-cycle timebase tick |
| duty_en_i | input | 1 | 1 = duty-cycled polling, 0 = continuous power |
| sleep_i | input | 1 | Forces every output low, sequencer idle |
| cs_i | input | 1 | Chip-select level gating the start of polling |
| pwr_mask_i | input | N_MOD | Per-module power enable mask |
| t_off_i | input | TIMER_W | Off phase length in ticks minus one |
| t_wake_i | input | WAKE_W | Wake phase length in ticks minus one |
| t_settle_i | input | TIMER_W | Settle phase length in ticks minus one |
| t_on_i | input | TIMER_W | Listen phase length in ticks minus one |
| line_i | input | 1 | Sampled level of the shared handshake line |
| line_drive_o | output | 1 | 1 = pull the handshake line low |
| mod_pwr_o | output | N_MOD | Module power enables |
| data_en_o | output | 1 | Received-data output enable |

## Verification
Two pairs of events can land on the same edge: a sleep request and a phase-ending tick, and the end of the listen phase and the sample of the host's line level. The first pair is forced by raising `sleep_i` in the very cycle whose tick would close a wake phase. The scoreboard then expects the outputs to drop on that tick, with no settle step after it. The second pair is covered by two runs. In one, the bench host never answers and the listen phase falls straight back to off on its final tick. In the other, the host holds the line, and the outputs must stay unchanged across that tick and for ten ticks after it.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_OFF    = 3'd1,
    PH_WAKE   = 3'd2,
    PH_SETTLE = 3'd3,
    PH_ON     = 3'd4,
    PH_HOLD   = 3'd5
  } rxw_phase_e;
endpackage

// File: rtl/rxw_phase_timer.sv
module rxw_phase_timer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         tick_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = tick_i && (cnt_q == '0);
endmodule

// File: rtl/rxw_seq_fsm.sv
module rxw_seq_fsm
  import rxw_pkg::*;
#(
  parameter int TIMER_W = 16,
  parameter int WAKE_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_ok_i,
  input  logic               cs_i,
  input  logic               line_i,
  input  logic               expire_i,
  input  logic [TIMER_W-1:0] t_off_i,
  input  logic [WAKE_W-1:0]  t_wake_i,
  input  logic [TIMER_W-1:0] t_settle_i,
  input  logic [TIMER_W-1:0] t_on_i,
  output rxw_phase_e         phase_o,
  output logic               load_o,
  output logic [TIMER_W-1:0] load_val_o
);
  localparam int PAD_W = TIMER_W - WAKE_W;

  rxw_phase_e ph_q, ph_d;

  always_comb begin
    ph_d       = ph_q;
    load_o     = 1'b0;
    load_val_o = t_off_i;
    if (!run_ok_i) begin
      ph_d = PH_IDLE;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (cs_i && line_i) begin
          ph_d   = PH_OFF;
          load_o = 1'b1;
        end
        PH_OFF: if (expire_i) begin
          ph_d       = PH_WAKE;
          load_o     = 1'b1;
          load_val_o = {{PAD_W{1'b0}}, t_wake_i};
        end
        PH_WAKE: if (expire_i) begin
          ph_d       = PH_SETTLE;
          load_o     = 1'b1;
          load_val_o = t_settle_i;
        end
        PH_SETTLE: if (expire_i) begin
          ph_d       = PH_ON;
          load_o     = 1'b1;
          load_val_o = t_on_i;
        end
        PH_ON: if (expire_i) begin
          // host still holding the line: stay awake
          if (!line_i) ph_d = PH_HOLD;
          else begin
            ph_d   = PH_OFF;
            load_o = 1'b1;
          end
        end
        PH_HOLD: if (line_i) begin
          ph_d   = PH_OFF;
          load_o = 1'b1;
        end
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= PH_IDLE;
    else         ph_q <= ph_d;
  end

  assign phase_o = ph_q;
endmodule

// File: rtl/rxw_pwr_gate.sv
module rxw_pwr_gate
  import rxw_pkg::*;
#(
  parameter int N_MOD = 4
) (
  input  rxw_phase_e       phase_i,
  input  logic             duty_en_i,
  input  logic             sleep_i,
  input  logic [N_MOD-1:0] pwr_mask_i,
  output logic [N_MOD-1:0] mod_pwr_o,
  output logic             line_drive_o,
  output logic             data_en_o
);
  logic powered, listen, cont;

  assign cont    = !duty_en_i;
  assign powered = (phase_i == PH_SETTLE) || (phase_i == PH_ON) || (phase_i == PH_HOLD);
  assign listen  = (phase_i == PH_ON) || (phase_i == PH_HOLD);

  for (genvar i = 0; i < N_MOD; i++) begin : g_mod
    assign mod_pwr_o[i] = !sleep_i && pwr_mask_i[i] && (cont || powered);
  end

  assign line_drive_o = !sleep_i && duty_en_i && (phase_i == PH_WAKE);
  assign data_en_o    = !sleep_i && (cont || listen);
endmodule

// File: rtl/rxw_wake_seq.sv
module rxw_wake_seq
  import rxw_pkg::*;
#(
  parameter int N_MOD   = 4,
  parameter int TIMER_W = 16,
  parameter int WAKE_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               duty_en_i,
  input  logic               sleep_i,
  input  logic               cs_i,
  input  logic [N_MOD-1:0]   pwr_mask_i,
  input  logic [TIMER_W-1:0] t_off_i,
  input  logic [WAKE_W-1:0]  t_wake_i,
  input  logic [TIMER_W-1:0] t_settle_i,
  input  logic [TIMER_W-1:0] t_on_i,
  input  logic               line_i,
  output logic               line_drive_o,
  output logic [N_MOD-1:0]   mod_pwr_o,
  output logic               data_en_o
);
  rxw_phase_e         phase;
  logic               load, expire, run_ok;
  logic [TIMER_W-1:0] load_val;

  assign run_ok = duty_en_i && !sleep_i;

  rxw_seq_fsm #(.TIMER_W(TIMER_W), .WAKE_W(WAKE_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_ok_i   (run_ok),
    .cs_i       (cs_i),
    .line_i     (line_i),
    .expire_i   (expire),
    .t_off_i    (t_off_i),
    .t_wake_i   (t_wake_i),
    .t_settle_i (t_settle_i),
    .t_on_i     (t_on_i),
    .phase_o    (phase),
    .load_o     (load),
    .load_val_o (load_val)
  );

  rxw_phase_timer #(.W(TIMER_W)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .tick_i     (tick_i),
    .expire_o   (expire)
  );

  rxw_pwr_gate #(.N_MOD(N_MOD)) u_gate (
    .phase_i      (phase),
    .duty_en_i    (duty_en_i),
    .sleep_i      (sleep_i),
    .pwr_mask_i   (pwr_mask_i),
    .mod_pwr_o    (mod_pwr_o),
    .line_drive_o (line_drive_o),
    .data_en_o    (data_en_o)
  );
endmodule

// File: rtl/rxw_wake_seq_chk.sv
module rxw_wake_seq_chk #(
  parameter int N_MOD = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             duty_en_i,
  input logic             sleep_i,
  input logic [N_MOD-1:0] pwr_mask_i,
  input logic             line_i,
  input logic             line_drive_o,
  input logic [N_MOD-1:0] mod_pwr_o,
  input logic             data_en_o
);
  assert_sleep_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> (mod_pwr_o == '0 && !line_drive_o && !data_en_o));

  assert_cont_power_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!duty_en_i && !sleep_i) |-> (mod_pwr_o == pwr_mask_i && data_en_o && !line_drive_o));

  assert_mask_kept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    duty_en_i |-> ((mod_pwr_o & ~pwr_mask_i) == '0));

  assert_data_needs_pwr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_en_i && data_en_o) |-> (mod_pwr_o == pwr_mask_i));

  assert_wake_exclusive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_drive_o |-> (!data_en_o && mod_pwr_o == '0));

  assert_wake_on_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_en_i && $rose(line_drive_o)) |-> $past(tick_i));

  assert_hold_keeps_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_en_o && !line_i && !tick_i && duty_en_i && !sleep_i)
      |=> (data_en_o || sleep_i || !duty_en_i));
endmodule

bind rxw_wake_seq rxw_wake_seq_chk #(.N_MOD(N_MOD)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick_i),
  .duty_en_i    (duty_en_i),
  .sleep_i      (sleep_i),
  .pwr_mask_i   (pwr_mask_i),
  .line_i       (line_i),
  .line_drive_o (line_drive_o),
  .mod_pwr_o    (mod_pwr_o),
  .data_en_o    (data_en_o)
);

// File: tb/tb_rxw_wake_seq.sv
`timescale 1ns/1ps
module tb_rxw_wake_seq;
  localparam int N = 4;
  localparam logic [N-1:0] MASK = 4'b0101;

  logic clk = 0, rst_n = 0, tick = 0;
  logic duty = 1, sleep = 0, cs = 0, host_low = 0, host_auto = 0, mon_en = 0;
  logic [N-1:0] mask = MASK;
  logic [15:0] t_off = 0, t_settle = 0, t_on = 0;
  logic [7:0]  t_wake = 0;
  logic line, drv, den;
  logic [N-1:0] pwr;

  int checks = 0, failures = 0, tick_no = 0, tph = 0;

  typedef struct {
    logic [N-1:0] pwr;
    logic drv;
    logic den;
    int   tk;
    string req;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;
  assign line = !(drv || host_low);

  rxw_wake_seq #(.N_MOD(N)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .duty_en_i(duty), .sleep_i(sleep),
    .cs_i(cs), .pwr_mask_i(mask), .t_off_i(t_off), .t_wake_i(t_wake),
    .t_settle_i(t_settle), .t_on_i(t_on), .line_i(line),
    .line_drive_o(drv), .mod_pwr_o(pwr), .data_en_o(den));

  // tick every 4th cycle
  always @(negedge clk) begin
    if (tph == 3) begin tick = 1; tick_no++; tph = 0; end
    else begin tick = 0; tph++; end
  end

  // host model: answers a wake pull-down by holding the line
  always @(negedge clk) if (host_auto && drv) host_low = 1;

  // monitor: every output change pops one expected item
  logic [N+1:0] prev = '0;
  always @(posedge clk) begin
    #1;
    if (mon_en && {pwr, drv, den} != prev) begin
      checks++;
      if (q.size() == 0) begin
        failures++;
        $display("FAIL unexpected change act=%b exp=<none> tick=%0d", {pwr, drv, den}, tick_no);
      end else begin
        exp_t e;
        e = q.pop_front();
        if ({pwr, drv, den} != {e.pwr, e.drv, e.den} || (e.tk >= 0 && e.tk != tick_no)) begin
          failures++;
          $display("FAIL %s act=%b@%0d exp=%b@%0d", e.req, {pwr, drv, den}, tick_no,
                   {e.pwr, e.drv, e.den}, e.tk);
        end
      end
      prev = {pwr, drv, den};
    end
  end

  task automatic push(logic [N-1:0] p, logic d, logic de, int tk, string req);
    exp_t e;
    e.pwr = p; e.drv = d; e.den = de; e.tk = tk; e.req = req;
    q.push_back(e);
  endtask

  task automatic quiet();
    do begin @(negedge clk); #1; end while (tick);
  endtask

  task automatic wait_ticks(int n);
    int t0 = tick_no;
    while (tick_no < t0 + n) @(negedge clk);
    quiet();
  endtask

  task automatic wait_empty();
    while (q.size() != 0) @(posedge clk);
    quiet();
  endtask

  task automatic check(logic ok, string req, logic [N+1:0] act, logic [N+1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  initial begin
    #600000;
    failures++;
    $display("FAIL watchdog act=running exp=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int s, t;
    repeat (3) @(negedge clk);
    #1;
    check({pwr, drv, den} == '0, "R1 in reset", {pwr, drv, den}, '0);
    rst_n = 1;
    quiet();
    check({pwr, drv, den} == '0, "R1 after reset", {pwr, drv, den}, '0);
    mon_en = 1;

    // R4 start gate: cs low, then line held low
    t_off = 2; t_wake = 1; t_settle = 0; t_on = 1;
    wait_ticks(6);
    check(drv == 0, "R4 cs low no start", {pwr, drv, den}, '0);
    cs = 1; host_low = 1;
    wait_ticks(6);
    check(drv == 0, "R4 line low no start", {pwr, drv, den}, '0);

    // R5/R6/R7/R8/R9: host never answers
    quiet();
    s = tick_no;
    push('0,   1, 0, s + 3,  "R6 wake drive");
    push(MASK, 0, 0, s + 5,  "R7 settle power");
    push(MASK, 0, 1, s + 6,  "R8 zero settle then listen");
    push('0,   0, 0, s + 8,  "R9 missed deadline");
    push('0,   1, 0, s + 11, "R5 second wake");
    host_low = 0;
    // R3 sleep lands on the tick that would end the wake phase
    do begin @(negedge clk); #1; end while (!(tick && tick_no == s + 13));
    push('0, 0, 0, s + 13, "R3 sleep beats expiry");
    sleep = 1;
    wait_empty();
    wait_ticks(5);
    check({pwr, drv, den} == '0, "R3 sleep hold", {pwr, drv, den}, '0);
    cs = 0;

    // R2 continuous mode and R3 override
    duty = 0;
    quiet();
    push(MASK, 0, 1, -1, "R2 continuous");
    sleep = 0;
    quiet(); quiet();
    check({pwr, drv, den} == {MASK, 2'b01}, "R2 continuous level", {pwr, drv, den}, {MASK, 2'b01});
    push('0, 0, 0, -1, "R3 sleep in continuous");
    sleep = 1;
    quiet(); quiet();
    push(MASK, 0, 1, -1, "R2 wake from sleep");
    sleep = 0;
    quiet(); quiet();
    push('0, 0, 0, -1, "R2 duty returns idle");
    duty = 1;
    wait_empty();

    // R10 host holds line
    t_off = 0; t_wake = 0; t_settle = 1; t_on = 0;
    host_auto = 1;
    quiet();
    s = tick_no;
    push('0,   1, 0, s + 1, "R5 zero off");
    push(MASK, 0, 0, s + 2, "R7 settle power");
    push(MASK, 0, 1, s + 4, "R8 listen");
    cs = 1;
    wait_empty();
    wait_ticks(10);
    check({pwr, drv, den} == {MASK, 2'b01}, "R10 hold active", {pwr, drv, den}, {MASK, 2'b01});
    t = tick_no;
    host_auto = 0;
    push('0,   0, 0, -1,    "R10 release");
    push('0,   1, 0, t + 1, "R10 off restart");
    push(MASK, 0, 0, t + 2, "R10 settle");
    push(MASK, 0, 1, t + 4, "R10 listen");
    push('0,   0, 0, t + 5, "R9 no answer");
    host_low = 0;
    wait_empty();
    sleep = 1;
    quiet(); quiet();
    check(q.size() == 0, "R5 scoreboard drained", N + 2'(q.size()), '0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule